// File: doc/BRIEF.md
# Inbound Address Window Translator

This block sits behind a bus target interface and decides whether an incoming address belongs to one of four programmable inbound windows. When it does, the block claims the request. It reports which window matched, picks the device-select timing code for the current bus mode, and converts the low 32 bits of the address into a 36-bit internal address.

Software sets up each window through a narrow write port. A write names a window, a field code and a 32-bit data word. Each window holds five fields:
- a low base word,
- a high base word,
- a mask-style limit word,
- a translate word,
- a 4-bit upper translate value.

Matching is a masked equality rather than a range compare. On dual-address cycles the high 32 address bits must equal the high base word exactly, with no masking.

A request presents a 64-bit address, a dual-address flag and a mode bit. All results appear on registered outputs one clock later.

Top module: `ibWinXlate`

## Requirements
- R1: After reset every window register is zero, `rspValid` is low, and any request misses because every window starts disabled.
- R2: A window matches when (`reqAddr[31:0]` AND limit) equals the low base word.
- R3: When `reqDac` is 1, a match also requires `reqAddr[63:32]` to equal the high base word in every bit, unmasked.
- R4: With the default parameter `SacNeedsZeroHi`=1, when `reqDac` is 0 the value of `reqAddr[63:32]` has no effect, and a window whose high base word is non-zero never matches.
- R5: When several windows match, the lowest-numbered window wins and is reported on `rspWin`.
- R6: A window whose limit word is zero never matches, even if its base would compare equal.
- R7: On a hit, `rspAddr[31:0]` = (`reqAddr[31:0]` AND NOT limit) OR (translate AND limit), and `rspAddr[35:32]` = upper translate of the winning window.
- R8: On a hit, `rspTiming` is 2'b01 (medium) when `modeExt`=0 and 2'b10 (decode A) when `modeExt`=1. On a miss it is 2'b00.
- R9: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. The results for that request appear in the same cycle. On a miss, `rspWin` and `rspAddr` are zero.
- R10: A write with `cfgWrEn`=1 stores `cfgData` into window `cfgWin` at field `cfgField`. The field codes are 0 low base, 1 high base, 2 limit, 3 translate and 4 upper translate (`cfgData[3:0]`). Codes 5 to 7 store nothing. A write in the same cycle as a request takes effect only from the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWin | input | 2 | Window selected by the write |
| cfgField | input | 3 | Field code of the write |
| cfgData | input | 32 | Write data |
| reqValid | input | 1 | Request present |
| reqAddr | input | 64 | Request address |
| reqDac | input | 1 | Dual-address cycle flag |
| modeExt | input | 1 | 1 = extended bus mode, 0 = conventional |
| rspValid | output | 1 | Result valid, one cycle after request |
| rspHit | output | 1 | Request claimed |
| rspWin | output | 2 | Winning window index |
| rspTiming | output | 2 | Device-select timing code |
| rspAddr | output | 36 | Translated internal address |

## Verification
The match is tried with several address patterns:
- addresses inside and just outside a masked window, which separate a masked equality from an unmasked one;
- dual-address requests whose high word differs in one position, which show that the high word is compared without masking;
- single-address requests carrying garbage in the high word, which show that it is ignored.

Overlapping windows show the lowest-index priority. A zero limit over a zero base is used to show that the window is disabled. Translated addresses mix the address and translate bits under a partial mask, so a swapped mask polarity or a dropped upper nibble shows up. A write issued in the same cycle as a request separates old-value from new-value use.

// File: rtl/ibWinPkg.sv
package ibWinPkg;
  localparam int NumWin   = 4;
  localparam int WinIdxW  = $clog2(NumWin);
  localparam int AddrW    = 64;
  localparam int LowW     = 32;
  localparam int IntW     = 36;
  localparam int UpW      = IntW - LowW;
  localparam int FieldW   = 3;

  typedef enum logic [FieldW-1:0] {
    FLD_BASE_LO = 3'd0,
    FLD_BASE_HI = 3'd1,
    FLD_LIMIT   = 3'd2,
    FLD_XLATE   = 3'd3,
    FLD_UPXL    = 3'd4
  } fieldT;

  typedef enum logic [1:0] {
    TIM_NONE     = 2'b00,
    TIM_MEDIUM   = 2'b01,
    TIM_DECODE_A = 2'b10
  } timingT;

  typedef struct packed {
    logic [NumWin-1:0] wrBaseLo;
    logic [NumWin-1:0] wrBaseHi;
    logic [NumWin-1:0] wrLimit;
    logic [NumWin-1:0] wrXlate;
    logic [NumWin-1:0] wrUpXl;
    logic              capture;
    logic              extMode;
  } strobeT;
endpackage

// File: rtl/ibWinCtrl.sv
module ibWinCtrl
  import ibWinPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [WinIdxW-1:0] cfgWin,
  input  logic [FieldW-1:0]  cfgField,
  input  logic               reqValid,
  input  logic               modeExt,
  output strobeT             strb
);
  logic [NumWin-1:0] winSel;

  always_comb begin
    winSel = '0;
    if (cfgWrEn) winSel[cfgWin] = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.capture  = reqValid;
    strb.extMode  = modeExt;
    case (fieldT'(cfgField))
      FLD_BASE_LO: strb.wrBaseLo = winSel;
      FLD_BASE_HI: strb.wrBaseHi = winSel;
      FLD_LIMIT:   strb.wrLimit  = winSel;
      FLD_XLATE:   strb.wrXlate  = winSel;
      FLD_UPXL:    strb.wrUpXl   = winSel;
      default:     ;
    endcase
  end

  // R10: a single write touches at most one field of one window
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrBaseLo, strb.wrBaseHi, strb.wrLimit, strb.wrXlate, strb.wrUpXl}));

  // R10: codes above the last field store nothing
  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (cfgField > 3'd4) |->
      ({strb.wrBaseLo, strb.wrBaseHi, strb.wrLimit, strb.wrXlate, strb.wrUpXl} == '0));
endmodule

// File: rtl/ibWinData.sv
module ibWinData
  import ibWinPkg::*;
#(
  parameter bit SacNeedsZeroHi = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [LowW-1:0]    cfgData,
  input  logic [AddrW-1:0]   reqAddr,
  input  logic               reqDac,
  output logic               rspValid,
  output logic               rspHit,
  output logic [WinIdxW-1:0] rspWin,
  output logic [1:0]         rspTiming,
  output logic [IntW-1:0]    rspAddr
);
  logic [LowW-1:0] baseLo [NumWin];
  logic [LowW-1:0] baseHi [NumWin];
  logic [LowW-1:0] limitR [NumWin];
  logic [LowW-1:0] xlateR [NumWin];
  logic [UpW-1:0]  upXlR  [NumWin];

  logic [NumWin-1:0] hitVec;
  logic              anyHit;
  logic [WinIdxW-1:0] selIdx;
  logic [IntW-1:0]   xlAddr;
  logic [NumWin-1:0] lowerMask;

  wire [LowW-1:0] addrLo = reqAddr[LowW-1:0];
  wire [LowW-1:0] addrHi = reqAddr[AddrW-1:LowW];

  // Window register file
  genvar gi;
  generate
    for (gi = 0; gi < NumWin; gi++) begin : gWin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          baseLo[gi] <= '0;
          baseHi[gi] <= '0;
          limitR[gi] <= '0;
          xlateR[gi] <= '0;
          upXlR[gi]  <= '0;
        end else begin
          if (strb.wrBaseLo[gi]) baseLo[gi] <= cfgData;
          if (strb.wrBaseHi[gi]) baseHi[gi] <= cfgData;
          if (strb.wrLimit[gi])  limitR[gi] <= cfgData;
          if (strb.wrXlate[gi])  xlateR[gi] <= cfgData;
          if (strb.wrUpXl[gi])   upXlR[gi]  <= cfgData[UpW-1:0];
        end
      end

      logic enabled;
      logic lowMatch;
      logic hiMatch;
      assign enabled  = |limitR[gi];
      assign lowMatch = (addrLo & limitR[gi]) == baseLo[gi];
      if (SacNeedsZeroHi) begin : gSacZero
        assign hiMatch = reqDac ? (addrHi == baseHi[gi]) : (baseHi[gi] == '0);
      end else begin : gSacFree
        assign hiMatch = reqDac ? (addrHi == baseHi[gi]) : 1'b1;
      end
      assign hitVec[gi] = enabled && lowMatch && hiMatch;
    end
  endgenerate

  // Lowest-index priority select
  always_comb begin
    selIdx = '0;
    for (int i = NumWin - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = WinIdxW'(i);
    end
  end
  assign anyHit = |hitVec;

  always_comb begin
    lowerMask = '0;
    for (int i = 0; i < NumWin; i++) begin
      if (WinIdxW'(i) < selIdx) lowerMask[i] = hitVec[i];
    end
  end

  // Translation through the winning window
  always_comb begin
    xlAddr = {upXlR[selIdx],
              (addrLo & ~limitR[selIdx]) | (xlateR[selIdx] & limitR[selIdx])};
  end

  // Result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspWin    <= '0;
      rspTiming <= TIM_NONE;
      rspAddr   <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) begin
        rspHit    <= anyHit;
        rspWin    <= anyHit ? selIdx : '0;
        rspAddr   <= anyHit ? xlAddr : '0;
        rspTiming <= !anyHit ? TIM_NONE : (strb.extMode ? TIM_DECODE_A : TIM_MEDIUM);
      end
    end
  end

  // R5: the chosen window matched and no lower window did
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (hitVec[selIdx] && (lowerMask == '0)));

  // R6: a window with a zero limit never reports a hit
  a_r6_zero_limit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && anyHit) |-> (limitR[selIdx] != '0));

  // R3: on a dual-address cycle the winner's high base equals the address high word
  a_r3_dac_upper: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && anyHit && reqDac) |-> (baseHi[selIdx] == addrHi));

  // R9: result valid exactly one cycle after a request
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rspValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> !rspValid);

  // R8: timing code is none exactly when there is no claim
  a_r8_timing_claim: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspTiming == TIM_NONE) == !rspHit));
endmodule

// File: rtl/ibWinXlate.sv
module ibWinXlate
  import ibWinPkg::*;
#(
  parameter bit SacNeedsZeroHi = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [WinIdxW-1:0] cfgWin,
  input  logic [FieldW-1:0]  cfgField,
  input  logic [LowW-1:0]    cfgData,
  input  logic               reqValid,
  input  logic [AddrW-1:0]   reqAddr,
  input  logic               reqDac,
  input  logic               modeExt,
  output logic               rspValid,
  output logic               rspHit,
  output logic [WinIdxW-1:0] rspWin,
  output logic [1:0]         rspTiming,
  output logic [IntW-1:0]    rspAddr
);
  strobeT strb;

  ibWinCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWin   (cfgWin),
    .cfgField (cfgField),
    .reqValid (reqValid),
    .modeExt  (modeExt),
    .strb     (strb)
  );

  ibWinData #(.SacNeedsZeroHi(SacNeedsZeroHi)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgData   (cfgData),
    .reqAddr   (reqAddr),
    .reqDac    (reqDac),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspWin    (rspWin),
    .rspTiming (rspTiming),
    .rspAddr   (rspAddr)
  );
endmodule

// File: tb/tb_ibWinXlate.sv
module tb_ibWinXlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWin = '0;
  logic [2:0]  cfgField = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        reqDac = 1'b0;
  logic        modeExt = 1'b0;
  logic        rspValid, rspHit;
  logic [1:0]  rspWin, rspTiming;
  logic [35:0] rspAddr;

  int nTests = 0;
  int nFail = 0;

  // bench model of the programmed windows
  logic [31:0] mBaseLo [4];
  logic [31:0] mBaseHi [4];
  logic [31:0] mLimit  [4];
  logic [31:0] mXlate  [4];
  logic [3:0]  mUpXl   [4];

  always #2 clk = ~clk;

  ibWinXlate dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWin(cfgWin),
    .cfgField(cfgField), .cfgData(cfgData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqDac(reqDac), .modeExt(modeExt),
    .rspValid(rspValid), .rspHit(rspHit), .rspWin(rspWin),
    .rspTiming(rspTiming), .rspAddr(rspAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int win, input int fld, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWin = 2'(win); cfgField = 3'(fld); cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (fld)
      0: mBaseLo[win] = data;
      1: mBaseHi[win] = data;
      2: mLimit[win]  = data;
      3: mXlate[win]  = data;
      4: mUpXl[win]   = data[3:0];
      default: ;
    endcase
  endtask

  task automatic setWin(input int w, input logic [31:0] bl, input logic [31:0] bh,
                        input logic [31:0] lim, input logic [31:0] xl, input logic [3:0] up);
    wr(w, 0, bl); wr(w, 1, bh); wr(w, 2, lim); wr(w, 3, xl); wr(w, 4, {28'd0, up});
  endtask

  // expected result computed from the requirements
  task automatic model(input logic [63:0] a, input logic dac, input logic ext,
                       output logic hit, output logic [1:0] win,
                       output logic [1:0] tim, output logic [35:0] ia);
    hit = 1'b0; win = '0; tim = 2'b00; ia = '0;
    for (int w = 0; w < 4; w++) begin
      logic ok;
      ok = (mLimit[w] != 0) && ((a[31:0] & mLimit[w]) == mBaseLo[w]);
      if (dac) ok = ok && (a[63:32] == mBaseHi[w]);
      else     ok = ok && (mBaseHi[w] == 0);
      if (ok && !hit) begin
        hit = 1'b1; win = 2'(w);
        tim = ext ? 2'b10 : 2'b01;
        ia = {mUpXl[w], (a[31:0] & ~mLimit[w]) | (mXlate[w] & mLimit[w])};
      end
    end
  endtask

  task automatic req(input string tag, input logic [63:0] a, input logic dac,
                     input logic ext, input logic expHitIn);
    logic h; logic [1:0] w, t; logic [35:0] ia;
    model(a, dac, ext, h, w, t, ia);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqDac = dac; modeExt = ext;
    @(negedge clk);
    reqValid = 1'b0;
    chk(tag, "valid", 64'(rspValid), 64'd1);
    chk(tag, "hit", 64'(rspHit), 64'(expHitIn));
    chk(tag, "hit(model)", 64'(rspHit), 64'(h));
    chk(tag, "win", 64'(rspWin), 64'(w));
    chk(tag, "timing", 64'(rspTiming), 64'(t));
    chk(tag, "addr", 64'(rspAddr), 64'(ia));
  endtask

  task automatic tReset();
    chk("R1", "valid after reset", 64'(rspValid), 64'd0);
    req("R1", 64'h0, 1'b0, 1'b0, 1'b0);
    req("R1", 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tBasic();
    setWin(0, 32'h8000_0000, 32'h0, 32'hFFF0_0000, 32'h0120_0000, 4'h5);
    req("R2", 64'h0000_0000_8003_4567, 1'b0, 1'b0, 1'b1);
    req("R7", 64'h0000_0000_800F_FFFF, 1'b0, 1'b0, 1'b1);
    chk("R7", "explicit addr", 64'(rspAddr), 64'h5_012F_FFFF);
    req("R2", 64'h0000_0000_8010_0000, 1'b0, 1'b0, 1'b0);
    chk("R9", "miss addr zero", 64'(rspAddr), 64'd0);
    req("R2", 64'h0000_0000_0003_4567, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tDac();
    setWin(1, 32'h4000_0000, 32'h0000_0001, 32'hC000_0000, 32'h8000_0000, 4'hA);
    req("R3", 64'h0000_0001_4000_1000, 1'b1, 1'b0, 1'b1);
    chk("R3", "win", 64'(rspWin), 64'd1);
    req("R3", 64'h0000_0003_4000_1000, 1'b1, 1'b0, 1'b0);
    req("R3", 64'h8000_0001_4000_1000, 1'b1, 1'b0, 1'b0);
    req("R4", 64'h0000_0001_4000_1000, 1'b0, 1'b0, 1'b0);
    req("R4", 64'hDEAD_BEEF_8000_0010, 1'b0, 1'b0, 1'b1);
    chk("R4", "win", 64'(rspWin), 64'd0);
    req("R3", 64'h0000_0001_8000_0010, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tPriority();
    setWin(2, 32'h0010_0000, 32'h0, 32'hFFF0_0000, 32'h0AB0_0000, 4'h2);
    setWin(3, 32'h0000_0000, 32'h0, 32'hFF00_0000, 32'h0C00_0000, 4'h3);
    req("R5", 64'h0000_0000_0012_3456, 1'b0, 1'b0, 1'b1);
    chk("R5", "win2 over win3", 64'(rspWin), 64'd2);
    req("R5", 64'h0000_0000_0022_3456, 1'b0, 1'b0, 1'b1);
    chk("R5", "win3 alone", 64'(rspWin), 64'd3);
    setWin(0, 32'h0000_0000, 32'h0, 32'hF000_0000, 32'h1000_0000, 4'h1);
    req("R5", 64'h0000_0000_0012_3456, 1'b0, 1'b0, 1'b1);
    chk("R5", "win0 over all", 64'(rspWin), 64'd0);
  endtask

  task automatic tDisabled();
    wr(0, 2, 32'h0); wr(2, 2, 32'h0); wr(3, 2, 32'h0);
    req("R6", 64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0);
    req("R6", 64'h0000_0000_0012_3456, 1'b0, 1'b1, 1'b0);
    chk("R8", "miss timing", 64'(rspTiming), 64'd0);
  endtask

  task automatic tTiming();
    wr(3, 2, 32'hFF00_0000);
    req("R8", 64'h0000_0000_0055_0000, 1'b0, 1'b1, 1'b1);
    chk("R8", "decode A", 64'(rspTiming), 64'd2);
    req("R8", 64'h0000_0000_0055_0000, 1'b0, 1'b0, 1'b1);
    chk("R8", "medium", 64'(rspTiming), 64'd1);
  endtask

  task automatic tWriteSameCycle();
    // window 3 hits 0x0055_0000; disable it in the same cycle as the request
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWin = 2'd3; cfgField = 3'd2; cfgData = 32'h0;
    reqValid = 1'b1; reqAddr = 64'h0000_0000_0055_0000; reqDac = 1'b0; modeExt = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk("R10", "old value used", 64'(rspHit), 64'd1);
    mLimit[3] = 32'h0;
    req("R10", 64'h0000_0000_0055_0000, 1'b0, 1'b0, 1'b0);
    // code 5 stores nothing: window 1 remains as programmed
    wr(1, 5, 32'h0);
    req("R10", 64'h0000_0001_4000_1000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tIdle();
    @(negedge clk);
    chk("R9", "idle valid", 64'(rspValid), 64'd0);
    @(negedge clk);
    chk("R9", "idle valid 2", 64'(rspValid), 64'd0);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      mBaseLo[w] = '0; mBaseHi[w] = '0; mLimit[w] = '0; mXlate[w] = '0; mUpXl[w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tDac();
    tPriority();
    tDisabled();
    tTiming();
    tWriteSameCycle();
    tIdle();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #400000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule